// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block turns a fixed 2.4576 MHz reference into the oversampling clock that a serial port needs. The port samples each bit sixteen times, so the block produces a square wave at sixteen times the selected baud rate. It also produces a one-cycle strobe at the same rate, so logic in the reference clock domain can use it as a clock enable.

A 3-bit rate code selects the divisor from a fixed table. A down counter counts one output period, and the counter's phase sets the level of the output. The divisor is sampled only when a period ends. A change of rate code therefore never cuts a period short. When the divisor is odd, the output stays high for one cycle longer than it stays low.

Top module: `baud_clk_gen`

## Requirements
- R1: While reset is high, at the first clock edge and at every later edge, `baud_x16` and `tick` are 0. Reset also loads the divisor for the current rate code.
- R2: On the first clock edge with reset low and enable high, `baud_x16` goes to 1 and `tick` pulses to 1.
- R3: With the default table and enable held high, the output period in reference clocks is 1396 for rate code 0 (110 baud), 512 for code 1 (300), 256 for code 2 (600), 128 for code 3 (1200), 64 for code 4 (2400), 32 for code 5 (4800) and 16 for code 6 (9600). Code 7 also gives 16.
- R4: For an even divisor N, `baud_x16` is high for the first N/2 cycles of each period and low for the last N/2 cycles.
- R5: For an odd divisor N (the table is a parameter, and every entry is at least 2), `baud_x16` is high for (N+1)/2 cycles and low for (N-1)/2 cycles.
- R6: `tick` is high for exactly one cycle per period: the first cycle of the period, which is also the cycle in which `baud_x16` rises.
- R7: A rate code change in the middle of a period has no effect until that period ends. The rate code present at the edge that starts a new period sets the length of that new period.
- R8: While enable is low, `baud_x16` holds its level, `tick` stays 0, and the position within the period is frozen. When enable returns high, counting continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.4576 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| rate_sel | input | 3 | Rate code, indexes the divisor table |
| baud_x16 | output | 1 | Square wave at 16x the baud rate |
| tick | output | 1 | One-cycle strobe at the start of each period |

## Verification
The ending of a period and a rate-code change can fall in the same cycle. The bench provokes this by changing the code exactly on the last cycle of a period, using a timing model of the period. It then requires that the very next period already has the new length, and it measures the gap between ticks to confirm this. The bench also changes the code in the middle of a period, to show that the current period keeps its old length. A second set of runs stops enable part way through a period, to show that the phase is frozen and then resumes. A second instance with an odd-valued table checks the asymmetric duty cycle.

// File: rtl/baud_clk_pkg.sv
package baud_clk_pkg;
  localparam int unsigned SEL_W_DEF = 3;
  localparam int unsigned CNT_W_DEF = 11;
  typedef int unsigned div_tab_t [8];
  // 2457600 / divisor = 16 x baud
  localparam div_tab_t DIV_TAB_DEF = '{1396, 512, 256, 128, 64, 32, 16, 16};
endpackage

// File: rtl/baud_rate_lut.sv
module baud_rate_lut #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned CNT_W = 11,
  parameter int unsigned DIV_TAB [2**SEL_W] = baud_clk_pkg::DIV_TAB_DEF
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] div
);
  localparam int unsigned NUM = 2**SEL_W;

  logic [CNT_W-1:0] rom [NUM];

  for (genvar gi = 0; gi < NUM; gi++) begin : g_rom
    assign rom[gi] = CNT_W'(DIV_TAB[gi]);
  end

  assign div = rom[sel];
endmodule

// File: rtl/baud_period_ctr.sv
module baud_period_ctr #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] div_sel,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] div_nxt,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] div_q;
  logic             reload;

  assign reload = (cnt_q == '0);

  always_comb begin
    cnt_nxt = cnt_q;
    div_nxt = div_q;
    if (en) begin
      if (reload) begin
        div_nxt = div_sel;
        cnt_nxt = div_sel - CNT_W'(1);
      end else begin
        cnt_nxt = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_q <= div_sel;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      div_q <= div_nxt;
      tick  <= en && reload;
    end
  end

  // R7: latched divisor only moves at a period boundary
  assert_div_held_R7: assert property (@(posedge clk) disable iff (rst)
    (!reload || !en) |=> $stable(div_q));

  // R6: strobe never lasts two cycles
  assert_tick_single_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/baud_wave_shaper.sv
module baud_wave_shaper #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] div_nxt,
  output logic             wave
);
  // high while remaining count is in the upper (ceil) half
  always_ff @(posedge clk) begin
    if (rst)     wave <= 1'b0;
    else if (en) wave <= (cnt_nxt >= (div_nxt >> 1));
  end
endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen #(
  parameter int unsigned SEL_W = baud_clk_pkg::SEL_W_DEF,
  parameter int unsigned CNT_W = baud_clk_pkg::CNT_W_DEF,
  parameter int unsigned DIV_TAB [2**SEL_W] = baud_clk_pkg::DIV_TAB_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             baud_x16,
  output logic             tick
);
  logic [CNT_W-1:0] div_sel;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] div_nxt;

  baud_rate_lut #(.SEL_W(SEL_W), .CNT_W(CNT_W), .DIV_TAB(DIV_TAB)) u_lut (
    .sel (rate_sel),
    .div (div_sel)
  );

  baud_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .div_sel (div_sel),
    .cnt_nxt (cnt_nxt),
    .div_nxt (div_nxt),
    .tick    (tick)
  );

  baud_wave_shaper #(.CNT_W(CNT_W)) u_wave (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .cnt_nxt (cnt_nxt),
    .div_nxt (div_nxt),
    .wave    (baud_x16)
  );

  // R1: reset forces both outputs low
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!baud_x16 && !tick));

  // R6: strobe coincides with the high half
  assert_tick_high_R6: assert property (@(posedge clk) disable iff (rst)
    tick |-> baud_x16);

  // R6: every rising edge of the wave carries a strobe
  assert_rise_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(baud_x16) |-> tick);

  // R8: disabled cycles freeze the wave and suppress the strobe
  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(baud_x16) && !tick));
endmodule

// File: tb/baud_clk_gen_test.sv
`timescale 1ns/1ps
module baud_clk_gen_test;
  localparam int unsigned DEF_TAB [8] = '{1396, 512, 256, 128, 64, 32, 16, 16};
  localparam int unsigned ODD_TAB [8] = '{5, 7, 3, 9, 2, 13, 4, 11};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [2:0] sel = 3'd0;
  logic sq_a, tk_a, sq_b, tk_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state, instance a (default table) and b (odd table)
  int unsigned n_a = 0, rem_a = 0, n_b = 0, rem_b = 0;
  bit eo_a = 0, et_a = 0, eo_b = 0, et_b = 0;

  always #5 clk = ~clk;

  baud_clk_gen uut (
    .clk(clk), .rst(rst), .en(en), .rate_sel(sel), .baud_x16(sq_a), .tick(tk_a)
  );

  baud_clk_gen #(.DIV_TAB(ODD_TAB)) uut_odd (
    .clk(clk), .rst(rst), .en(en), .rate_sel(sel), .baud_x16(sq_b), .tick(tk_b)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic adv(input int unsigned n_new, input bit r, input bit e,
                     inout int unsigned n, inout int unsigned rem, inout bit o, inout bit t);
    if (r) begin
      n = n_new; rem = 0; o = 0; t = 0;
    end else if (e) begin
      if (rem == 0) begin
        n = n_new; rem = n - 1; t = 1;
      end else begin
        rem = rem - 1; t = 0;
      end
      o = ((n - 1 - rem) < (n + 1) / 2);
    end else begin
      t = 0;
    end
  endtask

  // one clock: model follows inputs at the edge, compare at the falling edge
  task automatic cyc(input string req);
    @(posedge clk);
    adv(DEF_TAB[sel], rst, en, n_a, rem_a, eo_a, et_a);
    adv(ODD_TAB[sel], rst, en, n_b, rem_b, eo_b, et_b);
    @(negedge clk);
    chk(req, "wave a", int'(sq_a), int'(eo_a));
    chk("R6", "tick a", int'(tk_a), int'(et_a));
    chk(req, "wave b", int'(sq_b), int'(eo_b));
    chk("R6", "tick b", int'(tk_b), int'(et_b));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned na, nb, hi_a, hi_b, t2_a, t2_b, lim, gap;
    @(negedge clk);

    // R3/R4/R5 sweep over every rate code
    for (int code = 0; code < 8; code++) begin
      sel = 3'(code);
      rst = 1'b1; en = 1'b1;
      cyc("R1");
      cyc("R1");
      chk("R1", "reset wave a", int'(sq_a), 0);
      chk("R1", "reset tick a", int'(tk_a), 0);
      rst = 1'b0;
      cyc("R2");
      chk("R2", "first wave a", int'(sq_a), 1);
      chk("R2", "first tick a", int'(tk_a), 1);
      chk("R2", "first wave b", int'(sq_b), 1);
      chk("R2", "first tick b", int'(tk_b), 1);
      na = DEF_TAB[code]; nb = ODD_TAB[code];
      hi_a = 1; hi_b = 1; t2_a = 0; t2_b = 0;
      lim = 2 * ((na > nb) ? na : nb);
      for (int k = 1; k < int'(lim); k++) begin
        cyc("R3");
        if (k < int'(na) && sq_a) hi_a++;
        if (k < int'(nb) && sq_b) hi_b++;
        if (tk_a && t2_a == 0) t2_a = k;
        if (tk_b && t2_b == 0) t2_b = k;
      end
      chk("R3", $sformatf("period a code %0d", code), int'(t2_a), int'(na));
      chk("R3", $sformatf("period b code %0d", code), int'(t2_b), int'(nb));
      chk("R4", $sformatf("high a code %0d", code), int'(hi_a), int'(na / 2));
      chk("R5", $sformatf("high b code %0d", code), int'(hi_b), int'((nb + 1) / 2));
    end

    // R7: change mid-period, then change on the period's last cycle
    sel = 3'd3; rst = 1'b1; en = 1'b1;
    cyc("R1");
    rst = 1'b0;
    for (int k = 0; k < 40; k++) cyc("R7");
    sel = 3'd5;
    while (rem_a != 0) cyc("R7");
    chk("R7", "old period kept", int'(n_a), 128);
    sel = 3'd6;
    cyc("R7");
    chk("R7", "tick on reload", int'(tk_a), 1);
    gap = 0;
    do begin
      cyc("R7");
      gap++;
    end while (!tk_a && gap < 100);
    chk("R7", "new period at reload", int'(gap), 16);

    // R8: freeze mid-period
    sel = 3'd4;
    for (int k = 0; k < 70; k++) cyc("R8");
    for (int k = 0; k < 20; k++) cyc("R8");
    en = 1'b0;
    for (int k = 0; k < 12; k++) begin
      cyc("R8");
      chk("R8", "no tick while off", int'(tk_a), 0);
    end
    en = 1'b1;
    for (int k = 0; k < 150; k++) cyc("R8");

    // R1: reset mid-run
    rst = 1'b1;
    cyc("R1");
    chk("R1", "mid reset wave a", int'(sq_a), 0);
    chk("R1", "mid reset tick a", int'(tk_a), 0);
    rst = 1'b0;
    for (int k = 0; k < 20; k++) cyc("R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule